// File: doc/BRIEF.md
# Scope Sample Calibration Pipeline

This block turns raw 8-bit converter codes from an oscilloscope front end into 8-bit display values. Each sample enters on a valid/ready stream together with a one-bit channel tag. The block removes the fixed converter zero of 28 codes and normalises by multiplying with a supplied reciprocal of the range divisor. It scales by a span formed from the voltage setting and that channel's signed DC offset, adds the offset and a bias back, truncates toward zero and saturates to 0..255. All arithmetic is signed fixed point, and no floating point is involved.

In roll mode a channel whose probe code is above 220 uses a probe-compensated formula instead. That formula divides by a probe gain derived from the probe code, through a reciprocal table that is computed when the design is built. When the status fields say calibration must not run, the raw code passes through unchanged. The configuration and status inputs are plain pins. They must be held stable while samples are in flight, and the usual place to change them is between acquisitions.

The pipeline has three register stages that advance together. A stage moves whenever the output register is empty or the consumer takes its word, so `in_ready` follows `out_ready` combinationally whenever the output register is full. Samples leave in arrival order, each with the channel tag it entered with.

Top module: `scope_cal_pipe`

## Requirements
- R1: A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high; `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_code` and `out_chan` hold their values into the next cycle.
- R3: With `out_ready` held high, a sample accepted at edge k is presented on the output after edge k+2. At most three samples are in flight, and samples leave in order with their channel tag.
- R4: During and right after reset `out_valid` is low and `in_ready` is high.
- R5: Normal formula: d = code − 28; norm = floor(d·recip / 256), where `cfg_recip` is unsigned Q0.16 (289 ≈ 1/227); span = vrange − dc; q = norm·span + dc·256 + bias, with `cfg_bias` signed Q8.8 and q in Q.8.
- R6: A sample tagged 0 uses `cfg_dc_a` and `cfg_probe_a`; a sample tagged 1 uses `cfg_dc_b` and `cfg_probe_b`. In an interleaved stream, even positions carry tag 0.
- R7: The result q is converted to an integer by truncation toward zero. The integer is then saturated, so results above 255 give 255 and negative results give 0.
- R8: The output equals the raw code when any of these hold: `st_xfer` = 3, `st_tbase` ≥ 4, `st_selfcal` ≠ 0, or either probe code is 0x00 or 0xFF.
- R9: Compensated formula, used when `st_roll` = 1 and the sample's probe code p > 220: n = code + coff − dc; t = n·gain, where `cfg_cgain` is unsigned Q8.8; inv = floor(65536/(p − 28)); q = floor(t·inv / 65536) + dc·256 + bias. R7 then applies.
- R10: A probe code of 220 or below in roll mode, or any probe code when `st_roll` = 0, selects the normal formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_code | input | 8 | Raw converter code |
| in_chan | input | 1 | Channel tag (0 = first, 1 = second) |
| out_valid | output | 1 | Output value valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_code | output | 8 | Calibrated or passed-through value |
| out_chan | output | 1 | Channel tag of the output value |
| cfg_recip | input | 16 | Reciprocal of range divisor, unsigned Q0.16 |
| cfg_bias | input | 16 | Bias term, signed Q8.8 |
| cfg_vrange | input | 16 | Voltage range setting, signed integer |
| cfg_dc_a | input | 8 | Signed DC offset, channel 0 |
| cfg_dc_b | input | 8 | Signed DC offset, channel 1 |
| cfg_probe_a | input | 8 | Probe code, channel 0 |
| cfg_probe_b | input | 8 | Probe code, channel 1 |
| cfg_cgain | input | 16 | Probe gain constant, unsigned Q8.8 |
| cfg_coff | input | 8 | Signed offset constant of the compensated formula |
| st_xfer | input | 2 | Transfer mode status |
| st_tbase | input | 4 | Timebase index |
| st_selfcal | input | 8 | Self-calibration mode, 0 = off |
| st_roll | input | 1 | Roll mode active |

## Verification
On every cycle the assertions check the stream contract. They check that a stalled output holds its word and blocks the input, that the in-flight count never exceeds the three stages, that a valid output always has an accepted sample behind it, and that the pipeline is empty when reset is released. The numeric behaviour can only be shown by the bench's scenarios, which compare every delivered word against a behavioural model. These scenarios cover the normal formula on both offset selections, saturation at both ends, each bypass condition, and the probe threshold at 220/221 inside and outside roll mode. Random back-pressure is applied throughout.

// File: rtl/scal_pkg.sv
`timescale 1ns/1ps
package scal_pkg;
  localparam int CODE_W = 8;   // converter and display code width
  localparam int DC_W   = 8;   // signed per-channel DC offset width
  localparam int FRAC_W = 8;   // fractional bits of the working value
  localparam int INV_SH = 16;  // scale of the probe-gain reciprocal

  typedef struct packed {
    logic [CODE_W-1:0]      raw;
    logic                   chan;
    logic                   byp;
    logic                   comp;
    logic signed [DC_W-1:0] dc;
  } scal_tag_t;
endpackage

// File: rtl/scal_select.sv
`timescale 1ns/1ps
module scal_select
  import scal_pkg::*;
#(
  parameter int ZERO_CODE = 28,
  parameter int COMP_TH   = 220,
  parameter int TB_LIMIT  = 4,
  parameter int XFER_SKIP = 3,
  parameter int XFER_W    = 2,
  parameter int TB_W      = 4,
  parameter int CALM_W    = 8,
  parameter int VR_W      = 16,
  parameter int INV_W     = 9
) (
  input  logic [CODE_W-1:0]      code,
  input  logic                   chan,
  input  logic [CODE_W-1:0]      probe_a,
  input  logic [CODE_W-1:0]      probe_b,
  input  logic signed [DC_W-1:0] dc_a,
  input  logic signed [DC_W-1:0] dc_b,
  input  logic signed [VR_W-1:0] vrange,
  input  logic signed [DC_W-1:0] coff,
  input  logic [XFER_W-1:0]      xfer,
  input  logic [TB_W-1:0]        tbase,
  input  logic [CALM_W-1:0]      selfcal,
  input  logic                   roll,
  output scal_tag_t              tag,
  output logic signed [CODE_W:0]   d,
  output logic signed [CODE_W+2:0] n,
  output logic signed [VR_W:0]     span,
  output logic [INV_W-1:0]         inv
);
  localparam int NCOMP = (1 << CODE_W) - 1 - COMP_TH;
  localparam int IDX_W = $clog2(NCOMP);

  // reciprocal of (probe - zero) for every probe code above the threshold
  logic [INV_W-1:0] inv_tab [1 << IDX_W];
  for (genvar g = 0; g < (1 << IDX_W); g++) begin : g_inv
    if (g < NCOMP) begin : g_on
      assign inv_tab[g] = INV_W'((1 << INV_SH) / (COMP_TH + 1 + g - ZERO_CODE));
    end else begin : g_off
      assign inv_tab[g] = '0;
    end
  end

  logic [CODE_W-1:0]      probe_sel;
  logic signed [DC_W-1:0] dc_sel;
  logic                   no_probe;
  logic [IDX_W-1:0]       idx;

  always_comb begin
    probe_sel = chan ? probe_b : probe_a;
    dc_sel    = chan ? dc_b : dc_a;
    no_probe  = (probe_a == '0) || (probe_a == '1) ||
                (probe_b == '0) || (probe_b == '1);
    idx       = IDX_W'(int'(probe_sel) - (COMP_TH + 1));

    tag.raw  = code;
    tag.chan = chan;
    tag.dc   = dc_sel;
    tag.byp  = (xfer == XFER_W'(XFER_SKIP)) || (int'(tbase) >= TB_LIMIT) ||
               (selfcal != '0) || no_probe;
    tag.comp = roll && (int'(probe_sel) > COMP_TH);

    d    = $signed({1'b0, code}) - (CODE_W+1)'(ZERO_CODE);
    n    = $signed({3'b000, code}) + (CODE_W+3)'(coff) - (CODE_W+3)'(dc_sel);
    span = (VR_W+1)'(vrange) - (VR_W+1)'(dc_sel);
    inv  = tag.comp ? inv_tab[idx] : '0;
  end
endmodule

// File: rtl/scal_norm.sv
`timescale 1ns/1ps
module scal_norm
  import scal_pkg::*;
#(
  parameter int RECIP_W = 16,
  parameter int GAIN_W  = 16,
  parameter int VR_W    = 16,
  parameter int INV_W   = 9,
  parameter int A_W     = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     v_in,
  input  scal_tag_t                tag_in,
  input  logic signed [CODE_W:0]   d,
  input  logic signed [CODE_W+2:0] n,
  input  logic signed [VR_W:0]     span_in,
  input  logic [INV_W-1:0]         inv_in,
  input  logic [RECIP_W-1:0]       recip,
  input  logic [GAIN_W-1:0]        cgain,
  output logic                     v_out,
  output scal_tag_t                tag_out,
  output logic signed [A_W-1:0]    a_out,
  output logic signed [VR_W:0]     span_out,
  output logic [INV_W-1:0]         inv_out
);
  logic signed [A_W-1:0] a_nxt;

  always_comb begin
    if (tag_in.comp)
      a_nxt = A_W'(n) * A_W'($signed({1'b0, cgain}));
    else
      a_nxt = (A_W'(d) * A_W'($signed({1'b0, recip}))) >>> FRAC_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out    <= 1'b0;
      tag_out  <= '0;
      a_out    <= '0;
      span_out <= '0;
      inv_out  <= '0;
    end else if (en) begin
      v_out    <= v_in;
      tag_out  <= tag_in;
      a_out    <= a_nxt;
      span_out <= span_in;
      inv_out  <= inv_in;
    end
  end
endmodule

// File: rtl/scal_finish.sv
`timescale 1ns/1ps
module scal_finish
  import scal_pkg::*;
#(
  parameter int VR_W   = 16,
  parameter int BIAS_W = 16,
  parameter int INV_W  = 9,
  parameter int A_W    = 28,
  parameter int B_W    = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     v_in,
  input  scal_tag_t                tag_in,
  input  logic signed [A_W-1:0]    a_in,
  input  logic signed [VR_W:0]     span_in,
  input  logic [INV_W-1:0]         inv_in,
  input  logic signed [BIAS_W-1:0] bias,
  output logic                     v_out,
  output logic [CODE_W-1:0]        code_out,
  output logic                     chan_out
);
  logic signed [B_W-1:0] prod, total;
  logic [CODE_W-1:0]     sat;

  always_comb begin
    if (tag_in.comp)
      prod = (B_W'(a_in) * B_W'($signed({1'b0, inv_in}))) >>> INV_SH;
    else
      prod = B_W'(a_in) * B_W'(span_in);
    total = prod + (B_W'($signed(tag_in.dc)) <<< FRAC_W) + B_W'(bias);
    // negative values truncate toward zero and saturate to zero
    if (total[B_W-1])
      sat = '0;
    else if (|total[B_W-2:FRAC_W+CODE_W])
      sat = '1;
    else
      sat = total[FRAC_W+CODE_W-1:FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out    <= 1'b0;
      code_out <= '0;
      chan_out <= 1'b0;
    end else if (en) begin
      v_out    <= v_in;
      code_out <= tag_in.byp ? tag_in.raw : sat;
      chan_out <= tag_in.chan;
    end
  end
endmodule

// File: rtl/scope_cal_pipe.sv
`timescale 1ns/1ps
module scope_cal_pipe
  import scal_pkg::*;
#(
  parameter int ZERO_CODE = 28,
  parameter int COMP_TH   = 220,
  parameter int TB_LIMIT  = 4,
  parameter int XFER_SKIP = 3,
  parameter int XFER_W    = 2,
  parameter int TB_W      = 4,
  parameter int CALM_W    = 8,
  parameter int RECIP_W   = 16,
  parameter int VR_W      = 16,
  parameter int BIAS_W    = 16,
  parameter int GAIN_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CODE_W-1:0]        in_code,
  input  logic                     in_chan,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CODE_W-1:0]        out_code,
  output logic                     out_chan,
  input  logic [RECIP_W-1:0]       cfg_recip,
  input  logic signed [BIAS_W-1:0] cfg_bias,
  input  logic signed [VR_W-1:0]   cfg_vrange,
  input  logic signed [DC_W-1:0]   cfg_dc_a,
  input  logic signed [DC_W-1:0]   cfg_dc_b,
  input  logic [CODE_W-1:0]        cfg_probe_a,
  input  logic [CODE_W-1:0]        cfg_probe_b,
  input  logic [GAIN_W-1:0]        cfg_cgain,
  input  logic signed [DC_W-1:0]   cfg_coff,
  input  logic [XFER_W-1:0]        st_xfer,
  input  logic [TB_W-1:0]          st_tbase,
  input  logic [CALM_W-1:0]        st_selfcal,
  input  logic                     st_roll
);
  localparam int INV_W = $clog2(((1 << INV_SH) / (COMP_TH + 1 - ZERO_CODE)) + 1);
  localparam int D_W   = CODE_W + 1;
  localparam int N_W   = CODE_W + 3;
  localparam int A_NRM = D_W + RECIP_W + 1;
  localparam int A_CMP = N_W + GAIN_W + 1;
  localparam int A_W   = (A_NRM > A_CMP) ? A_NRM : A_CMP;
  localparam int M_W   = (VR_W + 1 > INV_W + 1) ? VR_W + 1 : INV_W + 1;
  localparam int B_W   = A_W + M_W + 2;

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // stage 1 inputs (combinational decode)
  scal_tag_t             tag0;
  logic signed [D_W-1:0] d0;
  logic signed [N_W-1:0] n0;
  logic signed [VR_W:0]  span0;
  logic [INV_W-1:0]      inv0;

  scal_select #(
    .ZERO_CODE(ZERO_CODE), .COMP_TH(COMP_TH), .TB_LIMIT(TB_LIMIT),
    .XFER_SKIP(XFER_SKIP), .XFER_W(XFER_W), .TB_W(TB_W), .CALM_W(CALM_W),
    .VR_W(VR_W), .INV_W(INV_W)
  ) u_sel (
    .code(in_code), .chan(in_chan), .probe_a(cfg_probe_a), .probe_b(cfg_probe_b),
    .dc_a(cfg_dc_a), .dc_b(cfg_dc_b), .vrange(cfg_vrange), .coff(cfg_coff),
    .xfer(st_xfer), .tbase(st_tbase), .selfcal(st_selfcal), .roll(st_roll),
    .tag(tag0), .d(d0), .n(n0), .span(span0), .inv(inv0)
  );

  // stage 1 registers
  logic                  v1;
  scal_tag_t             tag1;
  logic signed [D_W-1:0] d1;
  logic signed [N_W-1:0] n1;
  logic signed [VR_W:0]  span1;
  logic [INV_W-1:0]      inv1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; tag1 <= '0; d1 <= '0; n1 <= '0; span1 <= '0; inv1 <= '0;
    end else if (en) begin
      v1 <= in_valid; tag1 <= tag0; d1 <= d0; n1 <= n0; span1 <= span0; inv1 <= inv0;
    end
  end

  // stage 2
  logic                  v2;
  scal_tag_t             tag2;
  logic signed [A_W-1:0] a2;
  logic signed [VR_W:0]  span2;
  logic [INV_W-1:0]      inv2;

  scal_norm #(
    .RECIP_W(RECIP_W), .GAIN_W(GAIN_W), .VR_W(VR_W), .INV_W(INV_W), .A_W(A_W)
  ) u_norm (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(v1), .tag_in(tag1), .d(d1), .n(n1),
    .span_in(span1), .inv_in(inv1), .recip(cfg_recip), .cgain(cfg_cgain),
    .v_out(v2), .tag_out(tag2), .a_out(a2), .span_out(span2), .inv_out(inv2)
  );

  // stage 3 (output register)
  scal_finish #(
    .VR_W(VR_W), .BIAS_W(BIAS_W), .INV_W(INV_W), .A_W(A_W), .B_W(B_W)
  ) u_fin (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(v2), .tag_in(tag2), .a_in(a2),
    .span_in(span2), .inv_in(inv2), .bias(cfg_bias),
    .v_out(out_valid), .code_out(out_code), .chan_out(out_chan)
  );
endmodule

// File: rtl/scal_checker.sv
`timescale 1ns/1ps
module scal_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic              out_chan
);
  logic [2:0] inflight;
  logic       acc, del;
  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 3'(acc) - 3'(del);
  end

  // R1: a stalled output blocks new input
  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: stalled output word holds
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_chan)));

  // R3: never more samples in flight than stages
  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);

  // R3: a valid output always has an accepted sample behind it
  a_r3_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != 3'd0));

  // R4: pipeline empty when reset is released
  a_r4_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind scope_cal_pipe scal_checker #(.CODE_W(scal_pkg::CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_chan(out_chan)
);

// File: tb/scope_cal_pipe_tb.sv
`timescale 1ns/1ps
module scope_cal_pipe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, in_chan = 1'b0;
  logic [7:0]  in_code = '0;
  logic        out_valid, out_ready = 1'b1, out_chan;
  logic [7:0]  out_code;
  logic [15:0] recip = 16'd289, cgain = 16'd0;
  logic signed [15:0] bias = '0, vr = 16'sd200;
  logic signed [7:0]  dc_a = '0, dc_b = '0, coff = '0;
  logic [7:0]  pa = 8'd10, pb = 8'd10, selfcal = '0;
  logic [1:0]  xfer = 2'd2;
  logic [3:0]  tbase = 4'd1;
  logic        roll = 1'b0;

  scope_cal_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_chan(out_chan),
    .cfg_recip(recip), .cfg_bias(bias), .cfg_vrange(vr), .cfg_dc_a(dc_a),
    .cfg_dc_b(dc_b), .cfg_probe_a(pa), .cfg_probe_b(pb), .cfg_cgain(cgain),
    .cfg_coff(coff), .st_xfer(xfer), .st_tbase(tbase), .st_selfcal(selfcal),
    .st_roll(roll)
  );

  int checks = 0, fails = 0, stepn = 0;
  bit done = 0;
  bit lat_on = 0;
  string req = "R5";
  int    q_code[$], q_chan[$], q_step[$];
  string q_req[$];

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", r, act, exp, stepn);
    end
  endtask

  // behavioural model built from the requirement formulas
  function automatic int model(input int code, input int ch);
    longint dc, probe, q, iv;
    dc    = ch ? longint'(dc_b) : longint'(dc_a);
    probe = ch ? longint'(pb) : longint'(pa);
    if (xfer == 2'd3 || tbase >= 4 || selfcal != 0 ||
        pa == 8'h00 || pa == 8'hFF || pb == 8'h00 || pb == 8'hFF)
      return code;
    if (roll && probe > 220) begin
      longint n, t, inv;
      n   = longint'(code) + longint'(coff) - dc;
      t   = n * longint'(cgain);
      inv = 65536 / (probe - 28);
      q   = (t * inv) >>> 16;
    end else begin
      longint d, nm;
      d  = longint'(code) - 28;
      nm = (d * longint'(recip)) >>> 8;
      q  = nm * (longint'(vr) - dc);
    end
    q  = q + dc * 256 + longint'(bias);
    iv = (q < 0) ? -((-q) >>> 8) : (q >>> 8);
    if (iv < 0)   iv = 0;
    if (iv > 255) iv = 255;
    return int'(iv);
  endfunction

  task automatic step(input bit v, input int code, input bit ch, input bit rdy);
    @(negedge clk);
    in_valid = v; in_code = 8'(code); in_chan = ch; out_ready = rdy;
    #1;
    stepn++;
    if (out_valid && out_ready) begin
      if (q_code.size() == 0) begin
        check("R3 unexpected output", 1, 0);
      end else begin
        int ec, ecn, es; string er;
        ec = q_code.pop_front(); ecn = q_chan.pop_front();
        es = q_step.pop_front(); er = q_req.pop_front();
        check(er, int'(out_code), ec);
        check("R3 tag", int'(out_chan), ecn);
        if (lat_on) begin
          check("R3 latency", stepn - es, 3);
          lat_on = 0;
        end
      end
    end
    if (in_valid && in_ready) begin
      q_code.push_back(model(code, int'(ch)));
      q_chan.push_back(int'(ch));
      q_step.push_back(stepn);
      q_req.push_back(req);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    check("R3 drained", q_code.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset out_valid", int'(out_valid), 0);
    check("R4 reset in_ready", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    check("R4 after release out_valid", int'(out_valid), 0);
    check("R1 ready after release", int'(in_ready), 1);

    // normal formula, interleaved channels, latency
    dc_a = 8'sd5; dc_b = -8'sd10;
    req = "R5";
    lat_on = 1;
    step(1, 100, 0, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    req = "R6";
    for (int i = 0; i < 12; i++) step(1, 28 + i * 19, i[0], 1);
    drain();

    // saturation and truncation
    req = "R7";
    vr = 16'sd2000; step(1, 255, 0, 1); step(1, 20, 1, 1);
    bias = -16'sd100; vr = 16'sd200; step(1, 28, 0, 1); step(1, 29, 0, 1);
    drain();
    bias = 16'sd77; step(1, 0, 0, 1); step(1, 255, 1, 1); step(1, 140, 0, 1);
    drain();

    // random back-pressure
    req = "R2";
    for (int i = 0; i < 300; i++)
      step(($urandom % 3) != 0, $urandom % 256, $urandom % 2, ($urandom % 2) == 1);
    drain();

    // bypass conditions
    req = "R8";
    xfer = 2'd3;  step(1, 100, 0, 1); drain(); xfer = 2'd2;
    tbase = 4'd4; step(1, 101, 1, 1); drain(); tbase = 4'd3;
    selfcal = 8'd1; step(1, 102, 0, 1); drain(); selfcal = 8'd0;
    pa = 8'h00; step(1, 103, 1, 1); drain();
    pa = 8'hFF; step(1, 104, 0, 1); drain();
    pa = 8'd10; pb = 8'h00; step(1, 105, 0, 1); drain();
    pb = 8'hFF; step(1, 106, 1, 1); drain(); pb = 8'd10;
    step(1, 107, 0, 1); drain();

    // roll mode with compensation
    roll = 1'b1; cgain = 16'd51200; coff = -8'sd28; bias = 16'sd0;
    pa = 8'd230; pb = 8'd100;
    req = "R9";
    for (int i = 0; i < 6; i++) step(1, 30 + i * 40, 0, 1);
    req = "R10";
    for (int i = 0; i < 6; i++) step(1, 30 + i * 40, 1, 1);
    drain();
    req = "R10 threshold 220"; pa = 8'd220; step(1, 200, 0, 1); drain();
    req = "R9 threshold 221";  pa = 8'd221; pb = 8'd254; step(1, 200, 0, 1); step(1, 60, 1, 1); drain();
    req = "R10 not roll"; roll = 1'b0; step(1, 200, 0, 1); step(1, 60, 1, 1); drain();
    req = "R9 back-pressure"; roll = 1'b1;
    for (int i = 0; i < 60; i++)
      step(1, $urandom % 256, $urandom % 2, ($urandom % 3) != 0);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule